// File: doc/BRIEF.md
# Consecutive-Ones Run Detector

This block watches a serial bit stream that arrives one bit per clock, qualified by a valid strobe. It raises a registered detect flag whenever the most recent valid bits have all been ones for at least the match length, which defaults to three. Matches may overlap. A long run of ones therefore keeps the flag high for every extra one, and it does not fire once per separate group.

Inside, a small saturating counter tracks how many valid ones have arrived in a row. A valid zero clears the counter. A cycle with the strobe low changes nothing. The flag is computed from the counter's next value and registered, so it changes on the same edge that samples the bit that completes the match. The reset is synchronous and active low.

Top module: `serial_triple_detect`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `match_o` is 0 after that edge and the ones history is cleared, so three new valid ones are needed before the next detect.
- R2: `match_o` becomes 1 on the rising edge that samples the third consecutive valid 1 (`bit_vld`=1, `bit_in`=1).
- R3: A run of N consecutive valid ones followed by a valid 0 gives exactly max(N−2, 0) consecutive cycles with `match_o`=1. For the valid stream 0,1,1,1,1,1,0 this is three cycles.
- R4: A valid 0 (`bit_vld`=1, `bit_in`=0) drives `match_o` to 0 on the edge that samples it.
- R5: A cycle with `bit_vld`=0 is ignored. `match_o` and the run count both hold, so valid ones on either side of invalid cycles still count as consecutive.
- R6: The run count saturates at the match length. However long the run of ones, `match_o` stays 1 until a valid 0 or a reset arrives.
- R7: Two valid ones, then a valid 0, then a valid 1 do not produce a detect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data bit |
| match_o | output | 1 | Registered detect flag |

## Verification
The bench builds the block with its default match length of 3. This is the only value that lets the reference model be a plain three-bit shift register of the last valid bits. With that value, directed runs of length 0 to 8 reach the thresholds at two, three and beyond-saturation ones. Random streams with sparse strobes mix invalid cycles into runs and so test that history is kept across gaps.

// File: rtl/seqdet_pkg.sv
// Package: shared helpers for the consecutive-ones run detector.
// Assumes run lengths fit in a 32-bit int before being cast down.
package seqdet_pkg;

    // Next run count: clear on zero, increment on one, saturate at limit.
    function automatic int next_run(input int cur, input logic b, input int limit);
        if (!b)
            return 0;
        else if (cur >= limit)
            return limit;
        else
            return cur + 1;
    endfunction

endpackage

// File: rtl/ones_run_counter.sv
// Module: ones_run_counter
// Counts consecutive valid ones, saturating at MATCH_LEN.
// Exposes both the registered count and the value it will take next.
// Assumes synchronous active-low reset and MATCH_LEN >= 1.
module ones_run_counter
    import seqdet_pkg::*;
#(
    parameter int MATCH_LEN = 3,
    localparam int CNT_W = $clog2(MATCH_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [CNT_W-1:0] run_q,
    output logic [CNT_W-1:0] run_d
);

    // Next-state: hold when not valid, else apply the saturating rule.
    always_comb begin
        if (bit_vld)
            run_d = CNT_W'(next_run(int'(run_q), bit_in, MATCH_LEN));
        else
            run_d = run_q;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= run_d;
    end

    // R6: the count never passes the match length.
    p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) <= MATCH_LEN);

    // R4: a valid zero clears the count on the next edge.
    p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in) |=> (run_q == '0));

    // R5: an invalid cycle leaves the count unchanged.
    p_hold_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(run_q));

endmodule

// File: rtl/match_flag_reg.sv
// Module: match_flag_reg
// Registers the detect flag from the counter's next value.
// Assumes run_d already holds its value during invalid cycles.
module match_flag_reg #(
    parameter int MATCH_LEN = 3,
    localparam int CNT_W = $clog2(MATCH_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic [CNT_W-1:0] run_q,
    input  logic [CNT_W-1:0] run_d,
    output logic             flag_q
);

    logic hit_d;

    // Detect when the upcoming count reaches the saturated value.
    always_comb hit_d = (run_d == CNT_W'(MATCH_LEN));

    // Flag register; updates only on valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (bit_vld)
            flag_q <= hit_d;
    end

    // R1: reset forces the flag low.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !flag_q);

    // R2: a one completing the run raises the flag.
    p_third_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && run_d != run_q && run_d == CNT_W'(MATCH_LEN)) |=> flag_q);

    // R5: invalid cycles hold the flag.
    p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(flag_q));

endmodule

// File: rtl/serial_triple_detect.sv
// Module: serial_triple_detect (top)
// Overlapping detector for MATCH_LEN consecutive valid ones on a serial input.
// Assumes one qualified bit per cycle at most; synchronous active-low reset.
module serial_triple_detect #(
    parameter int MATCH_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match_o
);

    localparam int CNT_W = $clog2(MATCH_LEN + 1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;

    ones_run_counter #(.MATCH_LEN(MATCH_LEN)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .run_q   (run_q),
        .run_d   (run_d)
    );

    match_flag_reg #(.MATCH_LEN(MATCH_LEN)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .run_q   (run_q),
        .run_d   (run_d),
        .flag_q  (match_o)
    );

    // R4: a valid zero drops the flag on the sampling edge.
    p_zero_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in) |=> !match_o);

    // R7: the flag can only rise on a valid one.
    p_rise_on_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_o && !(bit_vld && bit_in)) |=> !match_o);

endmodule

// File: tb/serial_triple_detect_test.sv
// Scoreboard bench: the driver pushes expected flag values; the monitor compares.
module serial_triple_detect_test;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic match_o;

    item_t sb_q[$];
    int n_vec = 0;
    int n_bad = 0;
    logic [2:0] hist = 3'b000;
    logic model_flag = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_triple_detect uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .match_o (match_o)
    );

    // Drive one cycle, advance the reference, push the expected flag.
    task automatic drive(input logic rn, input logic v, input logic b, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = rn;
        bit_vld = v;
        bit_in = b;
        @(posedge clk);
        #1;
        if (!rn) begin
            hist = 3'b000;
            model_flag = 1'b0;
        end else if (v) begin
            hist = {hist[1:0], b};
            model_flag = &hist;
        end
        it.exp = model_flag;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic run_ones(input int n, input string tag);
        drive(1'b1, 1'b1, 1'b0, tag);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, tag);
        drive(1'b1, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compare every expected item against the output.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (match_o !== it.exp) begin
                n_bad++;
                $display("FAIL %s: match_o=%b expected %b at %0t", it.tag, match_o, it.exp, $time);
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 1'b1, 1'b1, "R1");
        // R2: third consecutive one raises the flag
        drive(1'b1, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b1, "R2");
        // R4: valid zero drops it
        drive(1'b1, 1'b1, 1'b0, "R4");
        // R1: reset mid-run clears history
        drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b0, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b1, "R1");
        // R3: runs of 0..8 ones, overlapping detects
        for (int n = 0; n <= 8; n++) run_ones(n, "R3");
        // R6: long run stays saturated
        run_ones(20, "R6");
        // R7: 1,1,0,1 must not detect
        drive(1'b1, 1'b1, 1'b1, "R7");
        drive(1'b1, 1'b1, 1'b1, "R7");
        drive(1'b1, 1'b1, 1'b0, "R7");
        drive(1'b1, 1'b1, 1'b1, "R7");
        drive(1'b1, 1'b1, 0, "R7");
        // R5: invalid cycles are ignored
        drive(1'b1, 1'b1, 1'b1, "R5");
        drive(1'b1, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b1, 1'b1, "R5");
        drive(1'b1, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b0, 1'b1, "R5");
        drive(1'b1, 1'b1, 1'b1, "R5");
        drive(1'b1, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b1, 1'b0, "R5");
        // Random streams (R3, R5)
        for (int k = 0; k < 3000; k++)
            drive(1'b1, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0), "R3");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule